// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Sequencer

This block sits inside an SDR SDRAM controller for a single rank. It owns the clock-enable pin and drives the command bus only while the memory moves into or out of a low-power state. The rest of the controller sends it level requests to enter power-down, enter self refresh, suspend the clock during a burst, or wake up. The block also reports that all banks are precharged and that a read or write burst is in progress.

The sequencer keeps a copy of the state it believes the memory is in. Each clock-enable edge it produces comes with the command the memory requires on that same edge. A power-down or self-refresh request made while banks are still open is held as pending. It takes effect on the first cycle in which all banks are precharged. Leaving self refresh opens an exit window of `T_XSR` cycles, with a minimum of 2. A NOP is issued on every cycle of that window. The ready flag tells the controller when it may issue normal commands again. A request that the current state does not allow produces a one-cycle error pulse and does not change the state.

Encodings: `state_o` is 0 for normal/all-idle, 1 for power-down, 2 for self refresh, 3 for clock suspend, 4 for power-down exit and 5 for self-refresh exit. `cmd_o` is 0 when the sequencer does not drive the bus, 1 for NOP and 2 for AUTO REFRESH.

Top module: `sdram_cke_seq`

## Requirements
- R1: After reset, cke_o=1, cmd_o=0, state_o=0, ready_o=1 and err_o=0.
- R2: In state 0, pd_req_i with all_idle_i=1 and burst_i=0 gives, one edge later, cke_o=0, cmd_o=1 (NOP), state_o=1 and ready_o=0.
- R3: In state 0, sr_req_i with all_idle_i=1 and burst_i=0 gives, one edge later, cke_o=0 together with cmd_o=2 (AUTO REFRESH) and state_o=2. From the following cycle cmd_o=1.
- R4: A power-down or self-refresh request made in state 0 while all_idle_i=0 leaves cke_o=1 and is kept pending even after the request drops. Entry happens on the first edge at which all_idle_i=1 and burst_i=0.
- R5: When self refresh and power-down are both requested or pending, self refresh is entered.
- R6: In state 0, susp_req_i with burst_i=1 gives cke_o=0, cmd_o=1 and state_o=3 one edge later. wake_req_i in state 3 gives cke_o=1, cmd_o=0, state_o=0 and ready_o=1 one edge later.
- R7: wake_req_i in state 1 gives exactly one cycle of state_o=4 with cke_o=1, cmd_o=1 and ready_o=0, followed by state_o=0 with ready_o=1.
- R8: wake_req_i in state 2 gives exactly T_XSR cycles of state_o=5 with cke_o=1, cmd_o=1 and ready_o=0, followed by state_o=0.
- R9: In states 1, 2 and 3 without wake_req_i, cke_o stays 0 and state_o does not change, whatever the other requests are.
- R10: err_o is 1 for the cycle after an edge that sampled a disallowed request, and 0 otherwise. Disallowed requests are: wake_req_i or susp_req_i without burst_i in state 0; pd_req_i, sr_req_i or susp_req_i in states 1–3; any request in states 4–5. The state is not altered by such a request.
- R11: ready_o=1 exactly when state_o=0, and it implies cke_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pd_req_i | input | 1 | Request power-down entry |
| sr_req_i | input | 1 | Request self-refresh entry |
| susp_req_i | input | 1 | Request clock suspend during a burst |
| wake_req_i | input | 1 | Request exit from the current low-power state |
| all_idle_i | input | 1 | All banks are precharged |
| burst_i | input | 1 | A read or write burst is in progress |
| cke_o | output | 1 | Clock-enable pin level |
| cmd_o | output | 2 | Command forced on the bus: 0 none, 1 NOP, 2 AUTO REFRESH |
| state_o | output | 3 | Tracked memory state (encoding above) |
| ready_o | output | 1 | Normal commands may be issued |
| err_o | output | 1 | One-cycle pulse for a disallowed request |

## Verification
All outputs are registered. A request sampled at one edge therefore shows up on cke_o, cmd_o, state_o and err_o after that edge, and ready_o follows state_o in the same cycle. The power-down exit takes two edges to return ready_o, and the self-refresh exit takes T_XSR+1 edges. The bench drives inputs on the falling edge and advances a requirement model on each rising edge. It compares every output on the next falling edge, so each result is checked in the cycle it is due. Directed sequences count those exit windows cycle by cycle.

// File: rtl/sdram_cke_pkg.sv
package sdram_cke_pkg;
  typedef enum logic [2:0] {
    ST_NORM = 3'd0,
    ST_PD   = 3'd1,
    ST_SR   = 3'd2,
    ST_SUSP = 3'd3,
    ST_PDX  = 3'd4,
    ST_SRX  = 3'd5
  } pst_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_NOP  = 2'd1,
    CMD_AREF = 2'd2
  } pcmd_e;
endpackage

// File: rtl/sdram_cke_xsr_timer.sv
module sdram_cke_xsr_timer #(
  parameter int T_XSR = 4,
  localparam int CNT_W = $clog2(T_XSR + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= CNT_W'(T_XSR - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_cke_pend.sv
module sdram_cke_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic pd_req_i,
  input  logic sr_req_i,
  input  logic clr_i,
  output logic pd_pend_o,
  output logic sr_pend_o
);
  // entry clears both, so a stale request cannot re-enter later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_pend_o <= 1'b0;
      sr_pend_o <= 1'b0;
    end else if (clr_i) begin
      pd_pend_o <= 1'b0;
      sr_pend_o <= 1'b0;
    end else if (arm_i) begin
      pd_pend_o <= pd_pend_o | pd_req_i;
      sr_pend_o <= sr_pend_o | sr_req_i;
    end
  end
endmodule

// File: rtl/sdram_cke_fsm.sv
module sdram_cke_fsm
  import sdram_cke_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pd_req_i,
  input  logic       sr_req_i,
  input  logic       susp_req_i,
  input  logic       wake_req_i,
  input  logic       all_idle_i,
  input  logic       burst_i,
  input  logic       pd_pend_i,
  input  logic       sr_pend_i,
  input  logic       xsr_zero_i,
  output logic       arm_o,
  output logic       clr_o,
  output logic       xsr_load_o,
  output logic       cke_o,
  output logic [1:0] cmd_o,
  output logic [2:0] state_o,
  output logic       err_o
);
  pst_e  st_q, st_d;
  pcmd_e cmd_q, cmd_d;
  logic  cke_q, cke_d, err_q, err_d;
  logic  sr_go, pd_go, any_req, lp_req;

  assign any_req = pd_req_i | sr_req_i | susp_req_i | wake_req_i;
  assign lp_req  = pd_req_i | sr_req_i | susp_req_i;
  assign sr_go   = (sr_req_i | sr_pend_i) & all_idle_i & ~burst_i;
  assign pd_go   = (pd_req_i | pd_pend_i) & all_idle_i & ~burst_i;

  always_comb begin
    st_d       = st_q;
    err_d      = 1'b0;
    xsr_load_o = 1'b0;
    unique case (st_q)
      ST_NORM: begin
        err_d = wake_req_i | (susp_req_i & ~burst_i);
        if (sr_go)                       st_d = ST_SR;
        else if (pd_go)                  st_d = ST_PD;
        else if (susp_req_i && burst_i)  st_d = ST_SUSP;
      end
      ST_PD: begin
        err_d = lp_req;
        if (wake_req_i) st_d = ST_PDX;
      end
      ST_SR: begin
        err_d = lp_req;
        if (wake_req_i) begin
          st_d       = ST_SRX;
          xsr_load_o = 1'b1;
        end
      end
      ST_SUSP: begin
        err_d = lp_req;
        if (wake_req_i) st_d = ST_NORM;
      end
      ST_PDX: begin
        err_d = any_req;
        st_d  = ST_NORM;
      end
      ST_SRX: begin
        err_d = any_req;
        if (xsr_zero_i) st_d = ST_NORM;
      end
      default: st_d = ST_NORM;
    endcase

    cke_d = !(st_d inside {ST_PD, ST_SR, ST_SUSP});
    if (st_q == ST_NORM && st_d == ST_SR) cmd_d = CMD_AREF;
    else if (st_d == ST_NORM)             cmd_d = CMD_NONE;
    else                                  cmd_d = CMD_NOP;
  end

  assign arm_o = (st_q == ST_NORM);
  assign clr_o = (st_q == ST_NORM) & (sr_go | pd_go);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_NORM;
      cmd_q <= CMD_NONE;
      cke_q <= 1'b1;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cmd_q <= cmd_d;
      cke_q <= cke_d;
      err_q <= err_d;
    end
  end

  assign cke_o   = cke_q;
  assign cmd_o   = cmd_q;
  assign state_o = st_q;
  assign err_o   = err_q;
endmodule

// File: rtl/sdram_cke_seq.sv
module sdram_cke_seq #(
  parameter int T_XSR = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pd_req_i,
  input  logic       sr_req_i,
  input  logic       susp_req_i,
  input  logic       wake_req_i,
  input  logic       all_idle_i,
  input  logic       burst_i,
  output logic       cke_o,
  output logic [1:0] cmd_o,
  output logic [2:0] state_o,
  output logic       ready_o,
  output logic       err_o
);
  logic arm, clr, xsr_load, xsr_zero, pd_pend, sr_pend;

  sdram_cke_pend u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm),
    .pd_req_i  (pd_req_i),
    .sr_req_i  (sr_req_i),
    .clr_i     (clr),
    .pd_pend_o (pd_pend),
    .sr_pend_o (sr_pend)
  );

  sdram_cke_xsr_timer #(.T_XSR(T_XSR)) u_xsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (xsr_load),
    .zero_o (xsr_zero)
  );

  sdram_cke_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pd_req_i   (pd_req_i),
    .sr_req_i   (sr_req_i),
    .susp_req_i (susp_req_i),
    .wake_req_i (wake_req_i),
    .all_idle_i (all_idle_i),
    .burst_i    (burst_i),
    .pd_pend_i  (pd_pend),
    .sr_pend_i  (sr_pend),
    .xsr_zero_i (xsr_zero),
    .arm_o      (arm),
    .clr_o      (clr),
    .xsr_load_o (xsr_load),
    .cke_o      (cke_o),
    .cmd_o      (cmd_o),
    .state_o    (state_o),
    .err_o      (err_o)
  );

  assign ready_o = (state_o == 3'd0);
endmodule

// File: rtl/sdram_cke_seq_chk.sv
module sdram_cke_seq_chk #(
  parameter int T_XSR = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wake_req_i,
  input logic       all_idle_i,
  input logic       cke_o,
  input logic [1:0] cmd_o,
  input logic [2:0] state_o,
  input logic       ready_o,
  input logic       err_o
);
  logic       prev_cke, prev_idle;
  logic [2:0] prev_st;
  int         srx_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_cke  <= 1'b1;
      prev_idle <= 1'b0;
      prev_st   <= 3'd0;
      srx_len   <= 0;
    end else begin
      prev_cke  <= cke_o;
      prev_idle <= all_idle_i;
      prev_st   <= state_o;
      srx_len   <= (state_o == 3'd5) ? srx_len + 1 : 0;
    end
  end

  p_fall_cmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_cke && !cke_o) |-> (cmd_o != 2'd0));
  p_aref_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_cke && !cke_o && cmd_o == 2'd2) |-> (state_o == 3'd2));
  p_idle_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_cke && !cke_o && (state_o == 3'd1 || state_o == 3'd2)) |-> prev_idle);
  p_pdx_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_st == 3'd4) |-> (state_o == 3'd0));
  p_srx_nop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5) |-> (cmd_o == 2'd1 && cke_o && !ready_o));
  p_srx_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_st == 3'd5 && state_o != 3'd5) |-> (srx_len == T_XSR));
  p_low_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prev_cke && !cke_o) |-> (state_o == prev_st));
  p_wake_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && wake_req_i) |=> err_o);
  p_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cke_o && state_o == 3'd0));
endmodule

bind sdram_cke_seq sdram_cke_seq_chk #(.T_XSR(T_XSR)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wake_req_i (wake_req_i),
  .all_idle_i (all_idle_i),
  .cke_o      (cke_o),
  .cmd_o      (cmd_o),
  .state_o    (state_o),
  .ready_o    (ready_o),
  .err_o      (err_o)
);

// File: tb/sdram_cke_seq_tb.sv
module sdram_cke_seq_tb;
  localparam int T_XSR = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pd_req = 0, sr_req = 0, susp_req = 0, wake_req = 0, all_idle = 1, burst = 0;
  logic cke, ready, err;
  logic [1:0] cmd;
  logic [2:0] st;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_st = 0, m_cnt = 0, m_cmd = 0;
  bit m_pdp = 0, m_srp = 0, m_err = 0, m_cke = 1;
  string m_tag = "R1";

  always #2.5 clk = ~clk;

  sdram_cke_seq #(.T_XSR(T_XSR)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .pd_req_i(pd_req), .sr_req_i(sr_req), .susp_req_i(susp_req), .wake_req_i(wake_req),
    .all_idle_i(all_idle), .burst_i(burst),
    .cke_o(cke), .cmd_o(cmd), .state_o(st), .ready_o(ready), .err_o(err)
  );

  task automatic model_upd();
    bit srg, pdg, anyr, lpr;
    anyr = pd_req | sr_req | susp_req | wake_req;
    lpr  = pd_req | sr_req | susp_req;
    m_err = 0;
    m_tag = "R9";
    case (m_st)
      0: begin
        srg = (sr_req | m_srp) & all_idle & !burst;
        pdg = (pd_req | m_pdp) & all_idle & !burst;
        m_err = wake_req | (susp_req & !burst);
        m_tag = (m_srp | m_pdp) ? "R4" : "R11";
        if (srg | pdg) begin
          m_tag = (srg & pdg) ? "R5" : (srg ? "R3" : "R2");
          if (!(sr_req | pd_req)) m_tag = "R4";
          m_srp = 0; m_pdp = 0;
        end else begin
          m_srp = m_srp | sr_req; m_pdp = m_pdp | pd_req;
        end
        if (srg)                  begin m_st = 2; m_cmd = 2; end
        else if (pdg)             begin m_st = 1; m_cmd = 1; end
        else if (susp_req & burst) begin m_st = 3; m_cmd = 1; m_tag = "R6"; end
        else m_cmd = 0;
      end
      1: begin m_err = lpr; m_cmd = 1; if (wake_req) begin m_st = 4; m_tag = "R7"; end end
      2: begin
        m_err = lpr; m_cmd = 1;
        if (wake_req) begin m_st = 5; m_cnt = T_XSR - 1; m_tag = "R8"; end
      end
      3: begin m_err = lpr; m_cmd = 1; if (wake_req) begin m_st = 0; m_cmd = 0; m_tag = "R6"; end end
      4: begin m_err = anyr; m_st = 0; m_cmd = 0; m_tag = "R7"; end
      default: begin
        m_err = anyr; m_tag = "R8";
        if (m_cnt == 0) begin m_st = 0; m_cmd = 0; end
        else begin m_cnt--; m_cmd = 1; end
      end
    endcase
    if (m_err) m_tag = "R10";
    m_cke = !(m_st inside {1, 2, 3});
  endtask

  task automatic compare(string tag);
    bit exp_rdy;
    exp_rdy = (m_st == 0);
    n_chk++;
    if (st !== 3'(m_st) || cke !== m_cke || cmd !== 2'(m_cmd) || ready !== exp_rdy || err !== m_err) begin
      n_fail++;
      $display("FAIL %s: actual st=%0d cke=%0b cmd=%0d rdy=%0b err=%0b expected st=%0d cke=%0b cmd=%0d rdy=%0b err=%0b",
               tag, st, cke, cmd, ready, err, m_st, m_cke, m_cmd, exp_rdy, m_err);
    end
  endtask

  task automatic cyc(string tag = "");
    @(posedge clk);
    model_upd();
    @(negedge clk);
    compare(tag == "" ? m_tag : tag);
  endtask

  task automatic clr_in();
    pd_req = 0; sr_req = 0; susp_req = 0; wake_req = 0; all_idle = 1; burst = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2 entry, R9 hold, R7 exit
    pd_req = 1; cyc("R2"); clr_in();
    sr_req = 1; cyc("R10"); clr_in();
    cyc("R9"); cyc("R9");
    wake_req = 1; cyc("R7"); clr_in();
    cyc("R7"); cyc("R7");

    // R3 entry with AUTO REFRESH, R8 exit window
    sr_req = 1; cyc("R3"); clr_in();
    cyc("R3"); cyc("R9");
    wake_req = 1; cyc("R8"); clr_in();
    for (int i = 0; i < T_XSR + 1; i++) cyc("R8");

    // R4 hold-off while banks open
    all_idle = 0; pd_req = 1; cyc("R4"); pd_req = 0;
    cyc("R4"); cyc("R4");
    all_idle = 1; cyc("R4");
    wake_req = 1; cyc("R7"); clr_in(); cyc("R7");

    // R5 priority
    pd_req = 1; sr_req = 1; cyc("R5"); clr_in();
    wake_req = 1; cyc("R8"); clr_in();
    for (int i = 0; i < T_XSR; i++) cyc("R8");

    // R6 clock suspend
    burst = 1; all_idle = 0; susp_req = 1; cyc("R6"); susp_req = 0;
    cyc("R9");
    wake_req = 1; cyc("R6"); clr_in();

    // R10 disallowed requests
    susp_req = 1; cyc("R10"); clr_in();
    cyc("R10");
    wake_req = 1; cyc("R10"); clr_in();
    cyc("R11");

    // constrained random
    void'($urandom(32'd4242));
    for (int i = 0; i < 4000; i++) begin
      pd_req   = ($urandom_range(0, 15) == 0);
      sr_req   = ($urandom_range(0, 19) == 0);
      susp_req = ($urandom_range(0, 11) == 0);
      wake_req = ($urandom_range(0, 5) == 0);
      all_idle = ($urandom_range(0, 3) != 0);
      burst    = ($urandom_range(0, 4) == 0);
      cyc();
    end
    clr_in();
    cyc();

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule